// File: doc/BRIEF.md
# Boot Stream Block Loader

The loader takes a byte-wide boot stream from a producer over a ready/valid pair and uses it to fill memory. The stream is a chain of blocks, and every block begins with a fixed 16-byte header. The header gives the block's destination address, its payload length and a final-block flag. The loader copies each payload byte to a byte-wide memory write port. The address starts at the header's destination and goes up by one for each byte.

The loader stays parked until it is told that the preparation phase is over. While parked, after the last block and whenever it cannot take a byte, it raises a host-wait output. A producer samples that output before every byte it sends. Once the final block is loaded, the loader raises a done flag and holds the entry address. The entry address is the destination address taken from the final block's header.

Top module: `boot_block_loader`

## Requirements
- R1: After a synchronous reset the loader is idle: `in_ready` = 0, `host_wait` = 1, `done` = 0, `mem_we` = 0, `entry_addr` = 0.
- R2: Before `load_go` is seen high in the idle state, no byte is accepted (`in_ready` = 0, `host_wait` = 1) and nothing is written, even with `in_valid` high.
- R3: Each header is exactly 16 accepted bytes, little-endian. Bytes 0–3 hold the destination address and bytes 4–7 the payload byte count. Bit 0 of byte 8 is the final-block flag. Bytes 9–15 are reserved and ignored. No header byte causes a memory write.
- R4: Each accepted payload byte is written exactly once. `mem_we` is high in the cycle after the accepting clock edge, with `mem_wdata` equal to the byte. `mem_addr` is the destination plus the byte's index within the block.
- R5: Any number of blocks follow one another in the same stream. Each block writes to its own destination.
- R6: A block with a byte count of zero writes nothing. The next accepted byte is byte 0 of a new header, or the loader finishes if the block is final.
- R7: From the edge that accepts the final block's last byte (or its last header byte when the count is zero), `done` = 1. `entry_addr` then equals that block's destination, `in_ready` = 0 and `host_wait` = 1. This holds until reset.
- R8: `host_wait` is always the complement of `in_ready`. With `in_valid` low, no byte is consumed and no write occurs.
- R9: Bits 7:1 of the flag byte have no effect. Only bit 0 marks the final block.
- R10: A reset asserted in the middle of a block returns the loader to the R1 state. A later stream is then loaded from a fresh header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_go | input | 1 | Preparation finished; starts loading from idle |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Loader takes the byte this cycle |
| host_wait | output | 1 | Producer must hold off |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| done | output | 1 | All blocks loaded |
| entry_addr | output | ADDR_W | Entry address of the loaded program |

## Verification
A payload write appears exactly one cycle after the clock edge that accepts its byte. `done` and `entry_addr` change at that same edge for the final byte. `in_ready` and `host_wait` follow the state with no further delay. The bench drives each byte at a falling edge and waits for the accepting rising edge. At the following falling edge it checks either the matching write or the absence of any write. The completion outputs are checked at that same falling edge. A sweep over payload lengths and producer gaps makes the timing hold both for back-to-back bytes and for bytes with stalls between them.

// File: rtl/boot_block_loader.sv
module boot_block_loader #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_go,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              host_wait,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              done,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam int HDR_LEN = 16;
  localparam int IDX_W   = $clog2(HDR_LEN);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY, S_DONE} st_t;

  st_t               st;
  logic [IDX_W-1:0]  hidx;
  logic [31:0]       hdr_addr;
  logic [31:0]       hdr_cnt;
  logic              last_blk;
  logic [ADDR_W-1:0] cursor;
  logic [31:0]       left;

  wire take = in_valid & in_ready;

  assign in_ready  = (st == S_HDR) || (st == S_PAY);
  assign host_wait = ~in_ready;
  assign done      = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      hidx       <= '0;
      hdr_addr   <= '0;
      hdr_cnt    <= '0;
      last_blk   <= 1'b0;
      cursor     <= '0;
      left       <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      entry_addr <= '0;
    end else begin
      mem_we <= 1'b0;
      case (st)
        S_IDLE: if (load_go) begin
          st   <= S_HDR;
          hidx <= '0;
        end
        S_HDR: if (take) begin
          hidx <= hidx + 1'b1;
          if (hidx < 4)
            hdr_addr[{hidx[1:0], 3'b000} +: 8] <= in_data;
          else if (hidx < 8)
            hdr_cnt[{hidx[1:0], 3'b000} +: 8] <= in_data;
          else if (hidx == 8)
            last_blk <= in_data[0];
          if (hidx == IDX_W'(HDR_LEN - 1)) begin
            cursor <= hdr_addr[ADDR_W-1:0];
            left   <= hdr_cnt;
            if (last_blk)
              entry_addr <= hdr_addr[ADDR_W-1:0];
            if (hdr_cnt != 0)
              st <= S_PAY;
            else if (last_blk)
              st <= S_DONE;
          end
        end
        S_PAY: if (take) begin
          mem_we    <= 1'b1;
          mem_addr  <= cursor;
          mem_wdata <= in_data;
          cursor    <= cursor + 1'b1;
          left      <= left - 1'b1;
          if (left == 32'd1)
            st <= last_blk ? S_DONE : S_HDR;
        end
        default: st <= S_DONE;
      endcase
    end
  end
endmodule

module boot_block_loader_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              load_go,
  input logic [7:0]        in_data,
  input logic              in_valid,
  input logic              in_ready,
  input logic              host_wait,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              done,
  input logic [ADDR_W-1:0] entry_addr
);
  // R4
  write_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(in_valid && in_ready));
  // R4
  write_data_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata == $past(in_data));
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + 1'b1);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done && $stable(entry_addr));
  // R7
  done_closed_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready && host_wait);
  // R8
  wait_polarity_chk: assert property (@(posedge clk) disable iff (rst)
    host_wait != in_ready);
endmodule

bind boot_block_loader boot_block_loader_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/boot_block_loader_tb.sv
module boot_block_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_go = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready, host_wait, mem_we, done;
  logic [AW-1:0] mem_addr, entry_addr;
  logic [7:0]    mem_wdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  boot_block_loader #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .load_go(load_go), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .host_wait(host_wait),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .entry_addr(entry_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int seed, input int i);
    return 8'(seed * 7 + i * 13 + 1);
  endfunction

  task automatic push(input logic [7:0] b, input int gap, input bit pay,
                      input logic [AW-1:0] ea, input string rq);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
    in_data  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (pay)
      check(mem_we && mem_addr == ea && mem_wdata == b, rq,
            {mem_we, 7'd0, mem_wdata, mem_addr}, {1'b1, 7'd0, b, ea});
    else
      check(!mem_we, rq, 64'(mem_we), 64'd0);
  endtask

  task automatic send_hdr(input logic [31:0] dst, input logic [31:0] cnt,
                          input logic [7:0] flag, input int gap);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b;
      if (i < 4)       b = dst[8*i +: 8];
      else if (i < 8)  b = cnt[8*(i-4) +: 8];
      else if (i == 8) b = flag;
      else             b = 8'hA5 ^ 8'(i * 17);
      push(b, gap, 1'b0, '0, "R3 header byte writes nothing");
    end
  endtask

  task automatic send_pay(input logic [31:0] dst, input int cnt, input int seed, input int gap);
    for (int i = 0; i < cnt; i++)
      push(pbyte(seed, i), gap, 1'b1, dst + 32'(i), "R4 payload write");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; load_go = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic go();
    load_go = 1'b1;
    @(negedge clk);
    load_go = 1'b0;
  endtask

  task automatic check_idle(input string rq);
    check(!in_ready && host_wait && !done && !mem_we && entry_addr == 0, rq,
          {59'd0, in_ready, host_wait, done, mem_we, |entry_addr}, 64'b01000);
  endtask

  task automatic check_done(input logic [31:0] dst, input string rq);
    check(done && entry_addr == dst && !in_ready && host_wait, rq,
          {29'd0, done, in_ready, host_wait, entry_addr}, {29'd0, 1'b1, 1'b0, 1'b1, dst});
  endtask

  initial begin
    do_reset();
    // R1
    check_idle("R1 reset state");

    // R2: offered bytes before go are refused
    in_data = 8'h5A; in_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!in_ready && host_wait && !mem_we, "R2 held off before go",
            {in_ready, host_wait, mem_we}, 3'b010);
    end
    in_valid = 1'b0;
    @(negedge clk);
    go();
    // R8
    check(in_ready && !host_wait, "R8 ready after go", {in_ready, host_wait}, 2'b10);

    // R5 multi-block stream, R6 zero count, R9 flag high bits ignored
    send_hdr(32'h0000_0100, 32'd5, 8'h00, 0);
    send_pay(32'h0000_0100, 5, 3, 0);
    send_hdr(32'h0000_2000, 32'd0, 8'hFE, 1);
    check(!done && in_ready, "R6 R9 zero block continues", {done, in_ready}, 2'b01);
    // R8: stall with valid low, nothing consumed
    repeat (4) begin
      @(negedge clk);
      check(!mem_we && in_ready, "R8 stall no write", {mem_we, in_ready}, 2'b01);
    end
    send_hdr(32'h0000_0030, 32'd3, 8'h81, 2);
    send_pay(32'h0000_0030, 3, 9, 1);
    check_done(32'h0000_0030, "R7 done after final block");
    // R7: further bytes refused
    in_data = 8'hEE; in_valid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(done && !in_ready && !mem_we, "R7 closed after done",
            {done, in_ready, mem_we}, 3'b100);
    end
    in_valid = 1'b0;

    // R3 R4 sweep over length and gap, single final block
    for (int n = 1; n <= 6; n++) begin
      for (int g = 0; g <= 2; g++) begin
        logic [31:0] dst;
        dst = 32'h1000_0000 + 32'(n * 64 + g * 3);
        do_reset();
        check_idle("R1 reset state in sweep");
        go();
        send_hdr(dst, 32'(n), 8'h01, g);
        send_pay(dst, n, n * 5 + g, g);
        check_done(dst, "R7 done in sweep");
      end
    end

    // R6 final block of zero length finishes at header end
    do_reset();
    go();
    send_hdr(32'hCAFE_0000, 32'd0, 8'h03, 0);
    check_done(32'hCAFE_0000, "R6 zero-length final block");

    // R10 reset mid-payload
    do_reset();
    go();
    send_hdr(32'h0000_0400, 32'd8, 8'h01, 0);
    send_pay(32'h0000_0400, 3, 1, 0);
    do_reset();
    check_idle("R10 reset mid-block");
    go();
    send_hdr(32'h0000_0800, 32'd2, 8'h01, 0);
    send_pay(32'h0000_0800, 2, 4, 0);
    check_done(32'h0000_0800, "R10 fresh stream after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule